// File: doc/BRIEF.md
# Serial PCM Output Formatter

This block turns a stream of stereo sample pairs into a three-wire audio link made of a bit clock, a word clock and one serial data line. The block runs on an oversampling master clock and divides that clock down to get the bit clock. The word clock is then generated from a slot counter that advances on every falling edge of the bit clock. A valid/ready handshake accepts one left/right pair at each word-clock boundary. If no pair is offered at a boundary, the last pair is sent again and an underrun flag is raised.

Four static configuration inputs control the output:
- the sample precision, which sets the number of slots in each half-frame;
- the bit order;
- a channel-routing mode;
- the master-clock-to-sample-rate ratio.

Input words are 24 bits wide. A sample narrower than 24 bits sits in the upper bits of the word. The configuration inputs may change only while reset is held.

Top module: `pcm_serial_tx`

## Requirements
- R1: During and right after reset, the outputs are: bit clock high, word clock high, data low, underrun low, ready low.
- R2: The ratio code 01, 10 or 11 selects 256, 384 or 512 master clocks per word period, and code 00 acts as 256. The bit clock period is that ratio divided by the slot count. The first falling edge of the bit clock comes half a period after reset is released.
- R3: Precision code 00 (16 bits) gives 32 slots per word period. Codes 01, 10 and 11 (18, 20 and 24 bits) give 64 slots. The word clock is low for the first half of the slots (left) and high for the second half (right).
- R4: Data and word clock change only in the master-clock cycle where the bit clock falls.
- R5: With bit-order flag 0, half-frame slot p (for p < W) carries input bit 23-p, where W is the precision. This sends the MSB first.
- R6: With bit-order flag 1, half-frame slot p (for p < W) carries input bit 24-W+p. This sends the LSB first.
- R7: Every slot from p = W up to the end of the half-frame carries 0.
- R8: Routing code 01 sends the right sample in both halves. Code 10 swaps the two channels. Codes 00 and 11 send left then right.
- R9: Ready is high for exactly one master-clock cycle, just before the bit-clock fall that starts slot 0. A pair accepted in that cycle is the pair sent in the frame that follows.
- R10: If valid is low while ready is high, the previous pair is sent again and underrun goes high. Underrun clears at the next boundary where a pair is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| prec_sel_i | input | 2 | Precision: 00=16, 01=18, 10=20, 11=24 bits |
| lsb_first_i | input | 1 | 1 sends LSB first |
| route_sel_i | input | 2 | Channel routing mode |
| ratio_sel_i | input | 2 | Master-clock ratio select |
| s_valid_i | input | 1 | Sample pair offered |
| s_ready_o | output | 1 | Pair accepted this cycle when valid |
| s_left_i | input | 24 | Left sample, left-justified |
| s_right_i | input | 24 | Right sample, left-justified |
| bclk_o | output | 1 | Bit clock |
| wclk_o | output | 1 | Word clock, low = left |
| sdata_o | output | 1 | Serial data |
| underrun_o | output | 1 | Last boundary found no pair |

## Verification
Three things happen in the same master-clock cycle at every word boundary:
- the handshake that loads a new pair;
- the bit-clock fall that drives slot 0;
- the word-clock change.

The first data bit of a frame must come from the pair that is being accepted in that very cycle. The bench exercises this at every frame of every configuration. It holds back valid for one boundary to force the underrun path in that same cycle. It then judges the result from the falling-edge index, which gives the expected frame number, pair, slot bit and underrun level.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;
    localparam int SLOT_W = 6;   // up to 64 slots per word period
    localparam int HALF_W = 4;   // bit clock half period up to 8 master clocks

    typedef enum logic [1:0] {
        ROUTE_NORMAL = 2'b00,
        ROUTE_RIGHT2 = 2'b01,
        ROUTE_SWAP   = 2'b10,
        ROUTE_RSVD   = 2'b11
    } route_e;
endpackage

// File: rtl/pcm_clkdiv.sv
module pcm_clkdiv
    import pcm_fmt_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [HALF_W-1:0] half_len_i,
    output logic              bclk_o,
    output logic              fall_o
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              bclk;
    } div_t;

    div_t st_q, st_d;
    logic wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == half_len_i - HALF_W'(1));
        if (wrap) begin
            st_d.cnt  = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.bclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk_o = st_q.bclk;
    assign fall_o = wrap & st_q.bclk;

    assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt < half_len_i);
endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
    import pcm_fmt_pkg::*;
#(
    parameter int DATA_W = 24
)(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fall_i,
    input  logic              wide_i,
    input  logic [1:0]        route_i,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] left_i,
    input  logic [DATA_W-1:0] right_i,
    output logic              ready_o,
    output logic [SLOT_W-1:0] slot_next_o,
    output logic [DATA_W-1:0] left_next_o,
    output logic [DATA_W-1:0] right_next_o,
    output logic              wclk_o,
    output logic              underrun_o
);
    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        logic [DATA_W-1:0] left;
        logic [DATA_W-1:0] right;
        logic              underrun;
    } frm_t;

    frm_t st_q, st_d;
    logic [SLOT_W-1:0] last_slot;
    logic              boundary;

    always_comb begin
        st_d      = st_q;
        last_slot = wide_i ? SLOT_W'(63) : SLOT_W'(31);
        boundary  = fall_i && (st_q.slot >= last_slot);
        if (boundary) begin
            st_d.slot = '0;
            if (valid_i) begin
                st_d.underrun = 1'b0;
                case (route_e'(route_i))
                    ROUTE_RIGHT2: begin st_d.left = right_i; st_d.right = right_i; end
                    ROUTE_SWAP:   begin st_d.left = right_i; st_d.right = left_i;  end
                    default:      begin st_d.left = left_i;  st_d.right = right_i; end
                endcase
            end else begin
                st_d.underrun = 1'b1;
            end
        end else if (fall_i) begin
            st_d.slot = st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.slot     <= '1;
            st_q.left     <= '0;
            st_q.right    <= '0;
            st_q.underrun <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o      = boundary;
    assign slot_next_o  = st_d.slot;
    assign left_next_o  = st_d.left;
    assign right_next_o = st_d.right;
    assign wclk_o       = wide_i ? st_q.slot[SLOT_W-1] : st_q.slot[SLOT_W-2];
    assign underrun_o   = st_q.underrun;

    assert_ready_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |=> !ready_o);
endmodule

// File: rtl/pcm_bitsel.sv
module pcm_bitsel
    import pcm_fmt_pkg::*;
#(
    parameter int DATA_W = 24
)(
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              wide_i,
    input  logic [1:0]        prec_i,
    input  logic              lsb_first_i,
    input  logic [DATA_W-1:0] left_i,
    input  logic [DATA_W-1:0] right_i,
    output logic              bit_o
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [SLOT_W-1:0] pos;
    logic [SLOT_W-1:0] width;
    logic              in_right;
    logic [DATA_W-1:0] word;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        case (prec_i)
            2'd0:    width = SLOT_W'(16);
            2'd1:    width = SLOT_W'(18);
            2'd2:    width = SLOT_W'(20);
            default: width = SLOT_W'(24);
        endcase
        in_right = wide_i ? slot_i[SLOT_W-1] : slot_i[SLOT_W-2];
        pos      = wide_i ? {1'b0, slot_i[SLOT_W-2:0]} : {2'b00, slot_i[SLOT_W-3:0]};
        word     = in_right ? right_i : left_i;
        if (lsb_first_i)
            idx = IDX_W'(SLOT_W'(DATA_W) - width + pos);
        else
            idx = IDX_W'(SLOT_W'(DATA_W - 1) - pos);
        bit_o = (pos < width) ? word[idx] : 1'b0;
    end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_fmt_pkg::*;
#(
    parameter int DATA_W = 24
)(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        prec_sel_i,
    input  logic              lsb_first_i,
    input  logic [1:0]        route_sel_i,
    input  logic [1:0]        ratio_sel_i,
    input  logic              s_valid_i,
    output logic              s_ready_o,
    input  logic [DATA_W-1:0] s_left_i,
    input  logic [DATA_W-1:0] s_right_i,
    output logic              bclk_o,
    output logic              wclk_o,
    output logic              sdata_o,
    output logic              underrun_o
);
    typedef struct packed {
        logic sdata;
    } out_t;

    logic              wide;
    logic [HALF_W-1:0] base_len;
    logic [HALF_W-1:0] half_len;
    logic              fall;
    logic [SLOT_W-1:0] slot_next;
    logic [DATA_W-1:0] left_next, right_next;
    logic              bit_next;
    out_t              out_q, out_d;

    always_comb begin
        wide     = (prec_sel_i != 2'b00);
        base_len = (ratio_sel_i == 2'b00) ? HALF_W'(2) : HALF_W'(ratio_sel_i) + HALF_W'(1);
        half_len = wide ? base_len : (base_len << 1);
    end

    pcm_clkdiv u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .half_len_i (half_len),
        .bclk_o     (bclk_o),
        .fall_o     (fall)
    );

    pcm_framer #(.DATA_W(DATA_W)) u_frm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .fall_i       (fall),
        .wide_i       (wide),
        .route_i      (route_sel_i),
        .valid_i      (s_valid_i),
        .left_i       (s_left_i),
        .right_i      (s_right_i),
        .ready_o      (s_ready_o),
        .slot_next_o  (slot_next),
        .left_next_o  (left_next),
        .right_next_o (right_next),
        .wclk_o       (wclk_o),
        .underrun_o   (underrun_o)
    );

    pcm_bitsel #(.DATA_W(DATA_W)) u_sel (
        .slot_i      (slot_next),
        .wide_i      (wide),
        .prec_i      (prec_sel_i),
        .lsb_first_i (lsb_first_i),
        .left_i      (left_next),
        .right_i     (right_next),
        .bit_o       (bit_next)
    );

    always_comb begin
        out_d = out_q;
        if (fall) out_d.sdata = bit_next;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) out_q.sdata <= 1'b0;
        else         out_q <= out_d;
    end

    assign sdata_o = out_q.sdata;

    assert_data_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sdata_o) |-> $fell(bclk_o));
    assert_wclk_on_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(wclk_o) |-> $fell(bclk_o));
    assert_ready_bclk_high_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_ready_o |-> bclk_o);
    assert_underrun_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(underrun_o) |-> $past(s_ready_o && !s_valid_i));
endmodule

// File: tb/tb_pcm_serial_tx.sv
module tb_pcm_serial_tx;
    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [1:0]  prec_sel = 2'd0, route_sel = 2'd0, ratio_sel = 2'd1;
    logic        lsb_first = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [23:0] s_left = '0, s_right = '0;
    logic        bclk, wclk, sdata, underrun;
    logic        done;
    int          n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    pcm_serial_tx dut (
        .clk_i(clk), .rst_ni(rst_ni), .prec_sel_i(prec_sel), .lsb_first_i(lsb_first),
        .route_sel_i(route_sel), .ratio_sel_i(ratio_sel), .s_valid_i(s_valid),
        .s_ready_o(s_ready), .s_left_i(s_left), .s_right_i(s_right),
        .bclk_o(bclk), .wclk_o(wclk), .sdata_o(sdata), .underrun_o(underrun)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (prec=%0d ratio=%0d lsb=%0d route=%0d)",
                     tag, act, exp, prec_sel, ratio_sel, lsb_first, route_sel);
        end
    endtask

    function automatic logic [23:0] pat_l(input int k);
        return 24'hA5C3F1 ^ (24'h13579B * 24'(k + 1)) ^ {prec_sel, ratio_sel, 20'h0};
    endfunction
    function automatic logic [23:0] pat_r(input int k);
        return {pat_l(k)[11:0], ~pat_l(k)[23:12]} ^ 24'h0F00F3;
    endfunction

    task automatic run_cfg(input int pr, input int ra, input int ls, input int rt,
                           input int frames, input int gap);
        int slots, half, wbits;
        prec_sel = 2'(pr); ratio_sel = 2'(ra); lsb_first = 1'(ls); route_sel = 2'(rt);
        slots = (pr == 0) ? 32 : 64;
        half  = ((ra == 3) ? 512 : (ra == 2) ? 384 : 256) / (2 * slots);
        wbits = (pr == 0) ? 16 : (pr == 1) ? 18 : (pr == 2) ? 20 : 24;
        rst_ni = 1'b0; s_valid = 1'b0; done = 1'b0;
        repeat (3) @(negedge clk);
        s_left = pat_l(0); s_right = pat_r(0); s_valid = 1'b1;
        rst_ni = 1'b1;
        #1;
        chk("R1 bclk", bclk, 1); chk("R1 wclk", wclk, 1); chk("R1 sdata", sdata, 0);
        chk("R1 underrun", underrun, 0); chk("R1 ready", s_ready, 0);
        fork
            begin : driver
                int idx = 0;
                while (!done) begin
                    @(negedge clk);
                    if (!done && s_ready) begin
                        if (s_valid) begin
                            @(posedge clk); #1;
                            idx++;
                            s_left = pat_l(idx); s_right = pat_r(idx);
                            if (idx == gap) s_valid = 1'b0;
                        end else begin
                            @(posedge clk); #1;
                            s_valid = 1'b1;
                        end
                    end
                end
            end
            begin : monitor
                int nf = 0, since = 0;
                logic pb = 1'b1, pw = 1'b1, pd = 1'b0;
                while (nf < frames * slots + 1) begin
                    @(negedge clk);
                    since++;
                    if (s_ready) begin
                        chk("R9 ready at boundary", int'(nf % slots == 0), 1);
                        chk("R9 ready timing", since, ((nf == 0) ? half : 2 * half) - 1);
                    end
                    if (pb && !bclk) begin
                        int slot = nf % slots;
                        int f = nf / slots;
                        int pid = (gap < 0 || f < gap) ? f : (f == gap ? gap - 1 : f - 1);
                        int p = slot % (slots / 2);
                        logic rside = (slot >= slots / 2);
                        logic [23:0] l = pat_l(pid), r = pat_r(pid), w;
                        logic eb;
                        string tg;
                        chk("R2 bclk interval", since, (nf == 0) ? half : 2 * half);
                        chk("R3 wclk level", wclk, int'(rside));
                        if (rt == 1)      w = r;
                        else if (rt == 2) w = rside ? l : r;
                        else              w = rside ? r : l;
                        if (p >= wbits) begin eb = 1'b0; tg = "R7 pad zero"; end
                        else if (ls != 0) begin eb = w[24 - wbits + p]; tg = (rt == 1 || rt == 2) ? "R8/R6 lsb" : "R6 lsb"; end
                        else begin eb = w[23 - p]; tg = (rt == 1 || rt == 2) ? "R8/R5 msb" : "R5 msb"; end
                        chk(tg, sdata, eb);
                        chk("R10 underrun", underrun, int'(gap >= 0 && f == gap));
                        nf++; since = 0;
                    end else begin
                        chk("R4 data stable", sdata, pd);
                        chk("R4 wclk stable", wclk, pw);
                    end
                    pb = bclk; pw = wclk; pd = sdata;
                end
                done = 1'b1;
            end
        join
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected < 190000 cycles", cyc);
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        done = 1'b0;
        for (int pr = 0; pr < 4; pr++)
            for (int ra = 1; ra < 4; ra++)
                for (int ls = 0; ls < 2; ls++)
                    run_cfg(pr, ra, ls, (pr * 6 + (ra - 1) * 2 + ls) % 4, 2, -1);
        run_cfg(0, 0, 0, 0, 2, -1);   // R2: code 00 behaves as 256
        run_cfg(2, 2, 0, 1, 4, 1);    // R10: one starved boundary
        run_cfg(3, 3, 1, 2, 4, 2);    // R10 with swap and LSB first
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule